// File: doc/BRIEF.md
# DDR2 Off-Chip Driver Calibration Responder

This block is the device-side sequencer for the off-chip driver calibration commands of a DDR2-style memory. A decoded mode command arrives on `cmd_valid`/`cmd_op`. The block answers in one of two ways. In either drive mode it switches every data and strobe output on at a fixed level after a configurable delay, which lets the controller measure the driver impedance. In adjust mode it takes a four-beat impedance pattern from the data inputs after the write latency and passes the four beats on to an impedance-code register.

Each command waits for its time to pass: the turn-on delay, the turn-off delay, the write latency and the write recovery after adjust data. A mode command that arrives while an earlier one is still in progress, or that does not fit the current mode, has no effect and raises a one-cycle protocol-error pulse. The data inputs come from the I/O cells already split into the beat captured on the rising strobe edge (`dq_rise_in`) and the beat captured on the falling edge (`dq_fall_in`), so one clock carries two beats. Configuration is read when the command that uses it is accepted.

Top module: `ocd_resp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to normal mode. After that edge every output enable is low, `dq_out`, `dqs_out` and `dqs_n_out` are low, and `adj_valid` and `proto_err` are low.
- R2: Drive-high is `cmd_op` = 2'b01. While it is active, all `dq_oe` bits and `dqs_oe` are 1, all `dq_out` bits are 1, `dqs_out` is 1 and `dqs_n_out` is 0.
- R3: Drive-low is `cmd_op` = 2'b10. While it is active, all `dq_oe` bits and `dqs_oe` are 1, all `dq_out` bits are 0, `dqs_out` is 0 and `dqs_n_out` is 1.
- R4: Say a drive command is sampled at edge N. The outputs stay high-Z through edge N+T-1 and are driven from edge N+T onward. T is `cfg_toit` as read at edge N, and a value of 0 counts as 1.
- R5: Exit is `cmd_op` = 2'b00. If it is sampled at edge M while drive is active, the drive levels hold through edge M+T-1 and all outputs return to high-Z at edge M+T, where T is defined as in R4.
- R6: Adjust is `cmd_op` = 2'b11. If it is sampled at edge N, the write latency WL is `cfg_al`+`cfg_cl`-1, with a minimum of 1. Beats DT0 and DT1 are `dq_rise_in` and `dq_fall_in` at edge N+WL. Beats DT2 and DT3 are `dq_rise_in` and `dq_fall_in` at edge N+WL+1. Input values at any other edge are ignored.
- R7: After edge N+WL+1, `adj_valid` is high for exactly one cycle. `adj_data` holds DTi in bits [i*DQ_W +: DQ_W], in this fixed order whatever burst ordering is in use, and keeps that value until the next capture.
- R8: After an adjust capture, a command sampled before edge N+WL+2+R is rejected, and one sampled at that edge or later is accepted. R is `cfg_twr` as read at edge N.
- R9: A command sampled while a turn-on, turn-off, latency or recovery wait is running is ignored, and `proto_err` is high for the one cycle after that edge.
- R10: While drive is active only exit is accepted. After an adjust capture and its recovery, adjust and exit are accepted and drive commands are rejected. Every rejection raises `proto_err` as in R9.
- R11: In normal mode and throughout adjust mode every output enable stays low. An exit in normal mode is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded mode command is present this cycle (low means no-operation) |
| cmd_op | input | 2 | Command: 00 exit, 01 drive-high, 10 drive-low, 11 adjust |
| cfg_toit | input | TOIT_W | Driver turn-on/turn-off delay in clocks |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_cl | input | LAT_W | CAS latency in clocks |
| cfg_twr | input | TWR_W | Write recovery after the adjust data, in clocks |
| dq_rise_in | input | DQ_W | Data beat captured on the rising strobe edge |
| dq_fall_in | input | DQ_W | Data beat captured on the falling strobe edge |
| dq_out | output | DQ_W | Data output values |
| dq_oe | output | DQ_W | Data output enables, one per lane |
| dqs_out | output | 1 | True strobe output value |
| dqs_n_out | output | 1 | Complement strobe output value |
| dqs_oe | output | 1 | Output enable shared by both strobes |
| adj_data | output | 4*DQ_W | Captured adjust beats, DT0 in the low lane |
| adj_valid | output | 1 | One-cycle pulse when a capture has completed |
| proto_err | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench builds the block with eight data lanes and four-bit configuration fields. With these values the write latency runs from its floor of 1 up to 29 clocks, and the turn-on delay and recovery both reach 15 clocks, so the shared down-counter is tested at its widest. The wider lane count means that misplacing a byte among the four captured beats, or swapping the rising and falling halves, changes `adj_data` in a way the bench can see. Random latencies and delays are mixed with directed cases at zero delay, at the minimum latency and at the first cycle that recovery allows.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  typedef enum logic [1:0] {
    OP_EXIT = 2'b00,
    OP_DRV1 = 2'b01,
    OP_DRV0 = 2'b10,
    OP_ADJ  = 2'b11
  } ocd_op_e;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_DRV_WAIT,
    ST_DRIVE,
    ST_EXIT_WAIT,
    ST_ADJ_WAIT,
    ST_ADJ_CAP,
    ST_ADJ_REC,
    ST_ADJ_HOLD
  } ocd_state_e;

endpackage

// File: rtl/ocd_seq.sv
// Mode sequencer: command acceptance, one shared wait counter, next-state
// signals for the registered output stages.
module ocd_seq
  import ocd_pkg::*;
#(
  parameter int LAT_W  = 4,
  parameter int TOIT_W = 4,
  parameter int TWR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TOIT_W-1:0] cfg_toit,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic [TWR_W-1:0]  cfg_twr,
  output logic              nxt_drive,
  output logic              nxt_level,
  output logic              cap_first,
  output logic              cap_second,
  output logic              reject
);

  localparam int LW    = LAT_W + 1;
  localparam int MX1   = (TOIT_W > TWR_W) ? TOIT_W : TWR_W;
  localparam int CNT_W = (LW > MX1) ? LW : MX1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ocd_state_e         state_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               lvl_q, lvl_n;
  logic [TWR_W-1:0]   twr_q, twr_n;

  ocd_op_e            op;
  logic [LW-1:0]      wl_sum;
  logic [CNT_W-1:0]   wl_eff;
  logic [CNT_W-1:0]   toit_eff;
  logic               expired;

  assign op       = ocd_op_e'(cmd_op);
  assign wl_sum   = LW'(cfg_al) + LW'(cfg_cl);
  assign wl_eff   = (wl_sum > LW'(1)) ? CNT_W'(wl_sum - LW'(1)) : ONE;
  assign toit_eff = (cfg_toit == '0) ? ONE : CNT_W'(cfg_toit);
  assign expired  = (cnt_q <= ONE);

  always_comb begin
    st_n       = state_q;
    cnt_n      = cnt_q;
    lvl_n      = lvl_q;
    twr_n      = twr_q;
    reject     = 1'b0;
    cap_first  = 1'b0;
    cap_second = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (cmd_valid) begin
          unique case (op)
            OP_DRV1: begin st_n = ST_DRV_WAIT; cnt_n = toit_eff; lvl_n = 1'b1; end
            OP_DRV0: begin st_n = ST_DRV_WAIT; cnt_n = toit_eff; lvl_n = 1'b0; end
            OP_ADJ:  begin st_n = ST_ADJ_WAIT; cnt_n = wl_eff;   twr_n = cfg_twr; end
            default: ;  // exit while normal: nothing to undo
          endcase
        end
      end
      ST_DRIVE: begin
        if (cmd_valid) begin
          if (op == OP_EXIT) begin
            st_n  = ST_EXIT_WAIT;
            cnt_n = toit_eff;
          end else begin
            reject = 1'b1;
          end
        end
      end
      ST_ADJ_HOLD: begin
        if (cmd_valid) begin
          unique case (op)
            OP_ADJ:  begin st_n = ST_ADJ_WAIT; cnt_n = wl_eff; twr_n = cfg_twr; end
            OP_EXIT: st_n = ST_NORMAL;
            default: reject = 1'b1;
          endcase
        end
      end
      ST_ADJ_CAP: begin
        reject     = cmd_valid;
        cap_second = 1'b1;
        if (twr_q == '0) begin
          st_n = ST_ADJ_HOLD;
        end else begin
          st_n  = ST_ADJ_REC;
          cnt_n = CNT_W'(twr_q);
        end
      end
      default: begin
        // all timed waits: DRV_WAIT, EXIT_WAIT, ADJ_WAIT, ADJ_REC
        reject = cmd_valid;
        if (expired) begin
          unique case (state_q)
            ST_DRV_WAIT:  st_n = ST_DRIVE;
            ST_EXIT_WAIT: st_n = ST_NORMAL;
            ST_ADJ_WAIT:  begin st_n = ST_ADJ_CAP; cap_first = 1'b1; end
            default:      st_n = ST_ADJ_HOLD;
          endcase
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
    endcase
  end

  assign nxt_drive = (st_n == ST_DRIVE) || (st_n == ST_EXIT_WAIT);
  assign nxt_level = lvl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      twr_q   <= '0;
    end else begin
      state_q <= st_n;
      cnt_q   <= cnt_n;
      lvl_q   <= lvl_n;
      twr_q   <= twr_n;
    end
  end

endmodule

// File: rtl/ocd_drive.sv
// Registered output stage: one value/enable pair per data lane plus strobes.
module ocd_drive #(
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nxt_drive,
  input  logic            nxt_level,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe,
  output logic            dqs_out,
  output logic            dqs_n_out,
  output logic            dqs_oe
);

  for (genvar g = 0; g < DQ_W; g++) begin : g_lane
    logic val_q, oe_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        val_q <= nxt_drive & nxt_level;
        oe_q  <= nxt_drive;
      end
    end
    assign dq_out[g] = val_q;
    assign dq_oe[g]  = oe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_out   <= 1'b0;
      dqs_n_out <= 1'b0;
      dqs_oe    <= 1'b0;
    end else begin
      dqs_out   <= nxt_drive & nxt_level;
      dqs_n_out <= nxt_drive & ~nxt_level;
      dqs_oe    <= nxt_drive;
    end
  end

endmodule

// File: rtl/ocd_adj_cap.sv
// Four-beat adjust capture in a fixed order: two beats per clock.
module ocd_adj_cap #(
  parameter int DQ_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_first,
  input  logic              cap_second,
  input  logic [DQ_W-1:0]   dq_rise_in,
  input  logic [DQ_W-1:0]   dq_fall_in,
  output logic [4*DQ_W-1:0] adj_data,
  output logic              adj_valid
);

  localparam int BEATS = 4;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    localparam bit IN_FIRST = (b < 2);
    localparam bit ON_RISE  = ((b % 2) == 0);
    logic [DQ_W-1:0] beat_q;
    logic            take;
    assign take = IN_FIRST ? cap_first : cap_second;
    always_ff @(posedge clk) begin
      if (rst)       beat_q <= '0;
      else if (take) beat_q <= ON_RISE ? dq_rise_in : dq_fall_in;
    end
    assign adj_data[b*DQ_W +: DQ_W] = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) adj_valid <= 1'b0;
    else     adj_valid <= cap_second;
  end

endmodule

// File: rtl/ocd_resp.sv
module ocd_resp #(
  parameter int DQ_W   = 4,
  parameter int LAT_W  = 4,
  parameter int TOIT_W = 4,
  parameter int TWR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TOIT_W-1:0] cfg_toit,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic [TWR_W-1:0]  cfg_twr,
  input  logic [DQ_W-1:0]   dq_rise_in,
  input  logic [DQ_W-1:0]   dq_fall_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  output logic              dqs_out,
  output logic              dqs_n_out,
  output logic              dqs_oe,
  output logic [4*DQ_W-1:0] adj_data,
  output logic              adj_valid,
  output logic              proto_err
);

  logic nxt_drive, nxt_level, cap_first, cap_second, reject;

  ocd_seq #(
    .LAT_W (LAT_W),
    .TOIT_W(TOIT_W),
    .TWR_W (TWR_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cfg_toit  (cfg_toit),
    .cfg_al    (cfg_al),
    .cfg_cl    (cfg_cl),
    .cfg_twr   (cfg_twr),
    .nxt_drive (nxt_drive),
    .nxt_level (nxt_level),
    .cap_first (cap_first),
    .cap_second(cap_second),
    .reject    (reject)
  );

  ocd_drive #(.DQ_W(DQ_W)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .nxt_drive(nxt_drive),
    .nxt_level(nxt_level),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .dqs_out  (dqs_out),
    .dqs_n_out(dqs_n_out),
    .dqs_oe   (dqs_oe)
  );

  ocd_adj_cap #(.DQ_W(DQ_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_first (cap_first),
    .cap_second(cap_second),
    .dq_rise_in(dq_rise_in),
    .dq_fall_in(dq_fall_in),
    .adj_data  (adj_data),
    .adj_valid (adj_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= reject;
  end

endmodule

// File: rtl/ocd_resp_chk.sv
module ocd_resp_chk #(
  parameter int DQ_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [DQ_W-1:0] dq_out,
  input logic [DQ_W-1:0] dq_oe,
  input logic            dqs_out,
  input logic            dqs_n_out,
  input logic            dqs_oe,
  input logic            adj_valid,
  input logic            proto_err
);

  // R4: data lanes and strobes are enabled together
  assert_oe_paired_R4: assert property (@(posedge clk) disable iff (rst)
    dq_oe == {DQ_W{dqs_oe}});

  // R2 / R3: while driven, data follows the true strobe and strobes are complementary
  assert_drive_levels_R2: assert property (@(posedge clk) disable iff (rst)
    dqs_oe |-> ((dqs_n_out == ~dqs_out) && (dq_out == {DQ_W{dqs_out}})));

  // R7: capture completion is a single-cycle pulse
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    adj_valid |=> !adj_valid);

  // R11: nothing is driven while adjust data is delivered
  assert_no_drive_adjust_R11: assert property (@(posedge clk) disable iff (rst)
    adj_valid |-> !dqs_oe);

  // R9: an error pulse always follows a presented command
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(cmd_valid));

  // R1: released outputs carry no level
  assert_hiz_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (!dqs_out && !dqs_n_out && (dq_out == '0)));

endmodule

bind ocd_resp ocd_resp_chk #(.DQ_W(DQ_W)) u_ocd_resp_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .dqs_out  (dqs_out),
  .dqs_n_out(dqs_n_out),
  .dqs_oe   (dqs_oe),
  .adj_valid(adj_valid),
  .proto_err(proto_err)
);

// File: tb/test_ocd_resp.sv
`timescale 1ns/1ps
module test_ocd_resp;

  localparam int DQ_W = 8;
  localparam logic [1:0] C_EXIT = 2'b00, C_DRV1 = 2'b01, C_DRV0 = 2'b10, C_ADJ = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'b00;
  logic [3:0]        cfg_toit = '0, cfg_al = '0, cfg_cl = '0, cfg_twr = '0;
  logic [DQ_W-1:0]   dq_rise_in = '0, dq_fall_in = '0;
  logic [DQ_W-1:0]   dq_out, dq_oe;
  logic              dqs_out, dqs_n_out, dqs_oe;
  logic [4*DQ_W-1:0] adj_data;
  logic              adj_valid, proto_err;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ocd_resp #(.DQ_W(DQ_W), .LAT_W(4), .TOIT_W(4), .TWR_W(4)) i_ocd_resp (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_toit(cfg_toit), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_twr(cfg_twr),
    .dq_rise_in(dq_rise_in), .dq_fall_in(dq_fall_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_n_out(dqs_n_out),
    .dqs_oe(dqs_oe), .adj_data(adj_data), .adj_valid(adj_valid), .proto_err(proto_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: ends just after the falling edge, outputs of the rising edge settled
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op);
    cmd_valid = 1'b1;
    cmd_op    = op;
    tick();
    cmd_valid = 1'b0;
    cmd_op    = 2'($urandom);
  endtask

  function automatic int eff_toit(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int exp_wl(input int al, input int cl);
    return (al + cl > 1) ? (al + cl - 1) : 1;
  endfunction

  task automatic chk_driven(input bit lvl, input string req);
    chk(req, "dqs_oe", 64'(dqs_oe), 64'd1);
    chk(req, "dq_oe", 64'(dq_oe), 64'({DQ_W{1'b1}}));
    chk(req, "dq_out", 64'(dq_out), 64'({DQ_W{lvl}}));
    chk(req, "dqs_out", 64'(dqs_out), 64'(lvl));
    chk(req, "dqs_n_out", 64'(dqs_n_out), 64'(!lvl));
  endtask

  task automatic chk_hiz(input string req);
    chk(req, "dqs_oe", 64'(dqs_oe), 64'd0);
    chk(req, "dq_oe", 64'(dq_oe), 64'd0);
  endtask

  // drive command from normal mode, checking the turn-on edge (R4)
  task automatic do_drive(input bit lvl, input int t);
    int te;
    te = eff_toit(t);
    cfg_toit = 4'(t);
    send(lvl ? C_DRV1 : C_DRV0);
    cfg_toit = 4'($urandom);
    chk("R9", "no error on drive accept", 64'(proto_err), 64'd0);
    chk_hiz("R4");
    repeat (te - 1) begin
      tick();
      chk_hiz("R4");
    end
    tick();
    chk_driven(lvl, lvl ? "R2" : "R3");
  endtask

  // exit from drive, checking hold and release edge (R5)
  task automatic do_exit_drive(input bit lvl, input int t);
    int te;
    te = eff_toit(t);
    cfg_toit = 4'(t);
    send(C_EXIT);
    cfg_toit = 4'($urandom);
    chk("R10", "exit accepted in drive", 64'(proto_err), 64'd0);
    chk_driven(lvl, "R5");
    repeat (te - 1) begin
      tick();
      chk_driven(lvl, "R5");
    end
    tick();
    chk_hiz("R5");
    chk("R5", "dq_out released", 64'(dq_out), 64'd0);
  endtask

  // adjust command: capture timing, order, pulse, recovery (R6,R7,R8)
  task automatic do_adjust(input int al, input int cl, input int twr);
    int wl;
    logic [DQ_W-1:0] d0, d1, d2, d3;
    wl = exp_wl(al, cl);
    d0 = DQ_W'($urandom); d1 = DQ_W'($urandom);
    d2 = DQ_W'($urandom); d3 = DQ_W'($urandom);
    cfg_al = 4'(al); cfg_cl = 4'(cl); cfg_twr = 4'(twr);
    send(C_ADJ);
    cfg_al = 4'($urandom); cfg_cl = 4'($urandom); cfg_twr = 4'($urandom);
    chk("R10", "adjust accepted", 64'(proto_err), 64'd0);
    repeat (wl - 1) begin
      dq_rise_in = DQ_W'($urandom); dq_fall_in = DQ_W'($urandom);
      chk("R6", "no early valid", 64'(adj_valid), 64'd0);
      chk_hiz("R11");
      tick();
    end
    dq_rise_in = d0; dq_fall_in = d1;
    chk("R6", "no early valid", 64'(adj_valid), 64'd0);
    tick();
    dq_rise_in = d2; dq_fall_in = d3;
    chk("R7", "valid not before second pair", 64'(adj_valid), 64'd0);
    tick();
    dq_rise_in = DQ_W'($urandom); dq_fall_in = DQ_W'($urandom);
    chk("R7", "valid pulse", 64'(adj_valid), 64'd1);
    chk("R6", "adj_data", 64'(adj_data), 64'({d3, d2, d1, d0}));
    chk_hiz("R11");
    if (twr > 0) begin
      send(C_DRV1);
      chk("R8", "command in recovery rejected", 64'(proto_err), 64'd1);
      chk("R7", "valid single cycle", 64'(adj_valid), 64'd0);
      repeat (twr - 1) begin
        tick();
        chk_hiz("R8");
      end
    end
    chk("R7", "data held", 64'(adj_data), 64'({d3, d2, d1, d0}));
  endtask

  task automatic exit_adjust();
    send(C_EXIT);
    chk("R10", "exit from adjust accepted", 64'(proto_err), 64'd0);
    chk_hiz("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h0CD5_2A17));
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_hiz("R1");
    chk("R1", "adj_valid", 64'(adj_valid), 64'd0);
    chk("R1", "proto_err", 64'(proto_err), 64'd0);
    chk("R1", "dq_out", 64'(dq_out), 64'd0);

    // R11 exit while normal is harmless
    send(C_EXIT);
    chk("R11", "exit in normal", 64'(proto_err), 64'd0);
    chk_hiz("R11");

    // boundary delays
    do_drive(1'b1, 0);
    do_exit_drive(1'b1, 0);
    do_drive(1'b0, 15);
    do_exit_drive(1'b0, 15);

    // R9 command during turn-on wait is ignored; drive still arrives on time
    cfg_toit = 4'd6;
    send(C_DRV1);              // edge N
    send(C_EXIT);              // edge N+1
    chk("R9", "busy command error", 64'(proto_err), 64'd1);
    tick();
    chk("R9", "error pulse one cycle", 64'(proto_err), 64'd0);
    repeat (2) begin tick(); chk_hiz("R9"); end   // N+3, N+4
    tick(); chk_hiz("R9");                        // N+5
    tick(); chk_driven(1'b1, "R9");               // N+6

    // R10 drive mode rejects other commands, levels unchanged
    send(C_DRV0);
    chk("R10", "drive0 in drive rejected", 64'(proto_err), 64'd1);
    chk_driven(1'b1, "R10");
    send(C_ADJ);
    chk("R10", "adjust in drive rejected", 64'(proto_err), 64'd1);
    repeat (4) begin tick(); chk_driven(1'b1, "R10"); end

    // R9 command during turn-off wait
    cfg_toit = 4'd3;
    send(C_EXIT);              // M
    send(C_DRV0);              // M+1
    chk("R9", "busy during exit", 64'(proto_err), 64'd1);
    chk_driven(1'b1, "R5");
    tick(); chk_driven(1'b1, "R5");   // M+2
    tick(); chk_hiz("R5");            // M+3
    repeat (8) begin tick(); chk_hiz("R9"); end

    // adjust boundaries: minimum latency, zero and one recovery, maximum latency
    do_adjust(0, 0, 0);
    do_adjust(1, 0, 1);
    send(C_DRV0);
    chk("R10", "drive in adjust rejected", 64'(proto_err), 64'd1);
    repeat (6) begin tick(); chk_hiz("R10"); end
    do_adjust(15, 15, 15);
    exit_adjust();
    do_drive(1'b0, 1);         // normal mode reached after adjust exit

    // R1 reset in the middle of drive
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_hiz("R1");
    chk("R1", "proto_err after reset", 64'(proto_err), 64'd0);
    tick();

    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 1) == 0) begin
        bit lvl;
        int hold;
        lvl  = 1'($urandom);
        do_drive(lvl, int'($urandom_range(0, 15)));
        hold = int'($urandom_range(0, 5));
        repeat (hold) begin tick(); chk_driven(lvl, lvl ? "R2" : "R3"); end
        do_exit_drive(lvl, int'($urandom_range(0, 15)));
      end else begin
        int reps;
        reps = int'($urandom_range(1, 2));
        for (int k = 0; k < reps; k++)
          do_adjust(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 6)));
        exit_adjust();
      end
      tick();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule